// File: doc/BRIEF.md
# Wide Register Subword Port

This block holds one register that is wider than the CPU data bus. The register is cut into subwords as wide as the bus, and each subword answers at its own byte address. A request carries an address, a write flag, write data and a per-bit write enable. The block turns the address into one strobe per subword. On a write, it moves the data and enables of the selected subword onto the writable fields that sit in that subword. On a read, it builds the subword from the readable fields and returns zero in every bit that no field covers. Stored field values go out to hardware on a flat vector. A read-only status field is taken from a hardware input and may cross a subword boundary. A writable field never crosses one.

Requests use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high when no response is pending, or when the pending response is being taken in the same cycle. Every accepted request gets exactly one response. While `rsp_valid` is high and `rsp_ready` is low, the response holds its value and new requests stall. The default layout is a 64-bit register on a 32-bit bus:

| Field | Bits | Access | Notes |
|---|---|---|---|
| F0 | [15:0] | read/write | |
| F1 | [23:16] | read/write | declared in reversed bit order |
| F2 | [47:24] | read-only | crosses from subword 0 into subword 1 |
| F3 | [63:56] | read/write | |

Bits [55:48] are not used.

Top module: `wide_reg_port`

## Requirements
- R1: The register has REG_W/BUS_W subwords. Subword i answers at BASE_ADDR + i*(BUS_W/8), so by default subword 0 is at 0x20 and subword 1 is at 0x24. BASE_ADDR must be a multiple of BUS_W/8. A request to any other address writes nothing and gets a zero response.
- R2: A subword strobe is active only for an accepted request whose address exactly equals that subword's address, and at most one strobe is active at a time. A misaligned address such as 0x21 selects no subword.
- R3: On a write, each writable field bit whose bus enable is 1 takes the bus data bit, and bits whose enable is 0 keep their value. A field's bus slice is its bit range minus (subword index × BUS_W), so F3 [63:56] is written from bus bits [31:24] at 0x24.
- R4: A write to one subword leaves every field in the other subwords unchanged.
- R5: Each writable field lies entirely inside one subword. This is checked when the design is built.
- R6: The read-only field F2 [47:24] returns its bits [31:24] in bus bits [31:24] of subword 0. It returns its bits [47:32] in bus bits [15:0] of subword 1. Writes have no effect on what it returns.
- R7: Read data bits not covered by a readable field are zero, for example bus bits [23:16] of subword 1. A write response carries all-zero data.
- R8: F1 is stored in reversed order. On write, bus bit 16+k sets stored bit 7-k. On read, stored bit 7-k appears on bus bit 16+k. `ctrl_q[16+j]` shows stored bit j.
- R9: A response appears on the first cycle after the request is accepted, with `rsp_valid` high.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` stays stable and `req_ready` is low. Responses come out in request order.
- R11: A synchronous active-high `rst` loads the writable fields from CTRL_RST and clears `rsp_valid`. By default F0 = 0xA5C3, stored F1 = 0x1E and F3 = 0x7B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can accept the request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | BUS_W | Write data |
| req_ben | input | BUS_W | Per-bit write enable |
| rsp_valid | output | 1 | A response is available |
| rsp_ready | input | 1 | The consumer takes the response |
| rsp_data | output | BUS_W | Read data, or zero for writes and misses |
| status_in | input | REG_W | Hardware values for the read-only fields, at their register positions |
| ctrl_q | output | REG_W | Stored writable field values at their register positions, zero elsewhere |

## Verification
The bench writes with partial enables. A design that ignores the enables, or that shifts the slice of the upper subword wrongly, puts the wrong bits into F0 or F3. The bench also reads both halves of the straddling status field after changing `status_in`. A design that clamps or offsets that field badly returns bits at the wrong place, or returns stale bits in the unused gap. The reversed field is written with an asymmetric pattern, so a missing reversal on either the write path or the read path shows up at once. Misaligned and out-of-range addresses, and stretches of response back-pressure, expose loose address matching, writes to a neighbouring subword, and responses that are dropped, reordered or changed while stalled.

// File: rtl/wreg_pkg.sv
package wreg_pkg;
  // Field layout of the register; positions assume the default 64-bit width.
  localparam int NFLD = 4;
  localparam int FLD_LO  [NFLD] = '{0, 16, 24, 56};
  localparam int FLD_HI  [NFLD] = '{15, 23, 47, 63};
  localparam bit FLD_WR  [NFLD] = '{1'b1, 1'b1, 1'b0, 1'b1};
  localparam bit FLD_REV [NFLD] = '{1'b0, 1'b1, 1'b0, 1'b0};
  localparam int FLD_MAX_HI = 63;
endpackage

// File: rtl/wreg_decode.sv
module wreg_decode #(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32,
  parameter int NSUB   = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic [NSUB-1:0]   strb
);
  localparam int SUB_BYTES = BUS_W / 8;

  // R1: the base address must fall on a bus-word boundary
  initial begin
    a_r1_base_aligned: assert ((int'(BASE_ADDR) % SUB_BYTES) == 0);
  end

  for (genvar i = 0; i < NSUB; i++) begin : g_sub
    localparam logic [ADDR_W-1:0] SUB_ADDR = ADDR_W'(int'(BASE_ADDR) + i * SUB_BYTES);
    assign strb[i] = req && (addr == SUB_ADDR);
  end
endmodule

// File: rtl/wreg_field.sv
module wreg_field #(
  parameter int REG_W = 64,
  parameter int BUS_W = 32,
  parameter int NSUB  = 2,
  parameter int LO    = 0,
  parameter int HI    = 15,
  parameter bit WRITABLE = 1'b1,
  parameter bit REVERSED = 1'b0,
  parameter logic [REG_W-1:0] RST_VEC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [NSUB-1:0]  sub_strb,
  input  logic [BUS_W-1:0] wdata,
  input  logic [BUS_W-1:0] wben,
  input  logic [REG_W-1:0] status_vec,
  output logic [REG_W-1:0] ctl_part,
  output logic [REG_W-1:0] rd_part
);
  localparam int W    = HI - LO + 1;
  localparam int SIDX = LO / BUS_W;
  localparam int OFF  = LO - SIDX * BUS_W;

  logic [W-1:0] val;

  if (WRITABLE) begin : g_rw
    logic [W-1:0] q, d, s;
    logic         wr_hit;
    logic         unused_rw;

    // R5: a writable field must sit inside one subword
    initial begin
      a_r5_confined: assert ((HI / BUS_W) == SIDX);
    end

    always_comb begin
      for (int j = 0; j < W; j++) begin
        d[j] = REVERSED ? wdata[OFF + W - 1 - j] : wdata[OFF + j];
        s[j] = REVERSED ? wben[OFF + W - 1 - j]  : wben[OFF + j];
      end
    end

    assign wr_hit = wr_en && sub_strb[SIDX];

    always_ff @(posedge clk) begin
      if (rst)         q <= RST_VEC[HI:LO];
      else if (wr_hit) q <= (q & ~s) | (d & s);
    end

    assign val       = q;
    assign unused_rw = ^{status_vec, wdata, wben, sub_strb};

    always_comb begin
      ctl_part = '0;
      ctl_part[HI:LO] = q;
    end

    a_r4_untouched: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && sub_strb[SIDX]) |=> $stable(q));
    a_r11_reset_load: assert property (@(posedge clk)
      rst |=> q == RST_VEC[HI:LO]);
  end else begin : g_ro
    logic unused_ro;
    assign val       = status_vec[HI:LO];
    assign ctl_part  = '0;
    assign unused_ro = ^{clk, rst, wr_en, sub_strb, wdata, wben, status_vec, RST_VEC};
  end

  // Place the field at its register position, mirrored when reversed.
  always_comb begin
    rd_part = '0;
    for (int j = 0; j < W; j++)
      rd_part[LO + j] = REVERSED ? val[W - 1 - j] : val[j];
  end
endmodule

// File: rtl/wreg_readback.sv
module wreg_readback #(
  parameter int REG_W = 64,
  parameter int BUS_W = 32,
  parameter int NSUB  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             we,
  input  logic [NSUB-1:0]  strb,
  input  logic [REG_W-1:0] rvec,
  input  logic             rsp_ready,
  output logic             rsp_valid,
  output logic [BUS_W-1:0] rsp_data
);
  logic [BUS_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NSUB; i++)
      if (strb[i] && !we) rd_word = rd_word | rvec[i*BUS_W +: BUS_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(strb));
  a_r2_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !accept |-> strb == '0);
  a_r9_next_cycle: assert property (@(posedge clk) disable iff (rst)
    accept |=> rsp_valid);
  a_r7_write_zero: assert property (@(posedge clk) disable iff (rst)
    accept && we |=> rsp_data == '0);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
endmodule

// File: rtl/wide_reg_port.sv
module wide_reg_port
  import wreg_pkg::*;
#(
  parameter int REG_W  = 64,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20,
  parameter logic [REG_W-1:0]  CTRL_RST  = 64'h7B00_0000_001E_A5C3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic [BUS_W-1:0]  req_ben,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BUS_W-1:0]  rsp_data,
  input  logic [REG_W-1:0]  status_in,
  output logic [REG_W-1:0]  ctrl_q
);
  localparam int NSUB = REG_W / BUS_W;

  initial begin
    a_r1_layout_fits: assert ((REG_W % BUS_W) == 0 && FLD_MAX_HI < REG_W);
  end

  logic            accept;
  logic [NSUB-1:0] strb;
  logic [REG_W-1:0] ctl_parts [NFLD];
  logic [REG_W-1:0] rd_parts  [NFLD];
  logic [REG_W-1:0] rvec;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  wreg_decode #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .NSUB(NSUB), .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .req(accept), .addr(req_addr), .strb(strb)
  );

  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    wreg_field #(
      .REG_W(REG_W), .BUS_W(BUS_W), .NSUB(NSUB),
      .LO(FLD_LO[f]), .HI(FLD_HI[f]),
      .WRITABLE(FLD_WR[f]), .REVERSED(FLD_REV[f]),
      .RST_VEC(CTRL_RST)
    ) u_field (
      .clk(clk), .rst(rst), .wr_en(accept && req_we), .sub_strb(strb),
      .wdata(req_wdata), .wben(req_ben), .status_vec(status_in),
      .ctl_part(ctl_parts[f]), .rd_part(rd_parts[f])
    );
  end

  always_comb begin
    ctrl_q = '0;
    rvec   = '0;
    for (int f = 0; f < NFLD; f++) begin
      ctrl_q = ctrl_q | ctl_parts[f];
      rvec   = rvec | rd_parts[f];
    end
  end

  wreg_readback #(
    .REG_W(REG_W), .BUS_W(BUS_W), .NSUB(NSUB)
  ) u_readback (
    .clk(clk), .rst(rst), .accept(accept), .we(req_we), .strb(strb),
    .rvec(rvec), .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: tb/wide_reg_port_bench.sv
module wide_reg_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A0 = 8'h20;
  localparam logic [7:0] A1 = 8'h24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic        req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [31:0] req_ben = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic [63:0] status_in = 64'h0123_4567_89AB_CDEF;
  logic [63:0] ctrl_q;

  int total = 0;
  int bad = 0;
  bit stall_mode = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  logic [15:0] m_f0 = 16'hA5C3;
  logic [7:0]  m_f1 = 8'h1E;
  logic [7:0]  m_f3 = 8'h7B;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_reg_port u_wide_reg_port (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata), .req_ben(req_ben),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .status_in(status_in), .ctrl_q(ctrl_q)
  );

  function automatic logic [7:0] rev8(input logic [7:0] x);
    for (int k = 0; k < 8; k++) rev8[k] = x[7-k];
  endfunction

  function automatic logic [31:0] exp_sub0();
    return {status_in[31:24], rev8(m_f1), m_f0};
  endfunction

  function automatic logic [31:0] exp_sub1();
    return {m_f3, 8'h00, status_in[47:32]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: computes the expected response, queues it, then performs the handshake.
  task automatic send(input string tag, input logic [7:0] a, input logic we,
                      input logic [31:0] wd, input logic [31:0] be);
    logic [31:0] e;
    e = 32'h0;
    if (!we && a == A0) e = exp_sub0();
    if (!we && a == A1) e = exp_sub1();
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd; req_ben = be;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
    if (we && a == A0) begin
      m_f0 = (m_f0 & ~be[15:0]) | (wd[15:0] & be[15:0]);
      m_f1 = (m_f1 & ~rev8(be[23:16])) | (rev8(wd[23:16]) & rev8(be[23:16]));
    end
    if (we && a == A1) m_f3 = (m_f3 & ~be[31:24]) | (wd[31:24] & be[31:24]);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 response one cycle after accept", {63'h0, rsp_valid}, 64'h1);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Response consumer: ready pattern changes just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (stall_mode) rsp_ready <= ($urandom_range(0, 2) == 0);
    else            rsp_ready <= 1'b1;
  end

  // Monitor: pops the scoreboard on each taken response and checks stalls.
  logic        held = 1'b0;
  logic [31:0] held_data = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (held) begin
        check("R10 response stable while stalled", {32'h0, rsp_data}, {32'h0, held_data});
        check("R10 valid kept while stalled", {63'h0, rsp_valid}, 64'h1);
      end
      if (rsp_valid && !rsp_ready)
        check("R10 request stalled behind response", {63'h0, req_ready}, 64'h0);
      held      = rsp_valid && !rsp_ready;
      held_data = rsp_data;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check("R10 unexpected response", 64'h1, 64'h0);
        end else begin
          string t;
          logic [31:0] e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {32'h0, rsp_data}, {32'h0, e});
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset value on ctrl_q", ctrl_q, {m_f3, 32'h0, m_f1, m_f0});
    check("R11 no response after reset", {63'h0, rsp_valid}, 64'h0);

    send("R11 R8 read subword 0 after reset", A0, 1'b0, '0, '0);
    send("R6 R7 read subword 1 after reset", A1, 1'b0, '0, '0);

    send("R7 write response zero", A0, 1'b1, 32'h1234_5678, 32'hFFFF_FFFF);
    drain();
    check("R3 R8 ctrl_q after full subword 0 write", ctrl_q, {m_f3, 32'h0, m_f1, m_f0});
    check("R8 reversed field stored value", {56'h0, ctrl_q[23:16]}, 64'h2C);
    send("R8 R6 readback subword 0", A0, 1'b0, '0, '0);

    send("R3 partial enable write", A0, 1'b1, 32'hFFFF_FF00, 32'h0000_00FF);
    drain();
    check("R3 partial enable leaves masked bits", {48'h0, ctrl_q[15:0]}, 64'h5600);

    send("R3 write subword 1", A1, 1'b1, 32'hAA55_11CC, 32'hFFFF_FFFF);
    drain();
    check("R4 subword 1 write keeps subword 0 fields", {40'h0, ctrl_q[23:0]}, {40'h0, m_f1, m_f0});
    check("R3 F3 from upper bus bits", {56'h0, ctrl_q[63:56]}, 64'hAA);
    send("R6 R7 readback subword 1 after write", A1, 1'b0, '0, '0);

    send("R1 write to unmapped address", 8'h28, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    send("R1 read unmapped address", 8'h28, 1'b0, '0, '0);
    send("R2 misaligned address selects nothing", 8'h21, 1'b0, '0, '0);
    send("R2 misaligned write ignored", 8'h22, 1'b1, 32'h0, 32'hFFFF_FFFF);
    drain();
    check("R1 R2 no change from stray writes", ctrl_q, {m_f3, 32'h0, m_f1, m_f0});

    @(negedge clk);
    status_in = 64'hFEDC_BA98_7654_3210;
    send("R6 straddling field low part", A0, 1'b0, '0, '0);
    send("R6 straddling field high part", A1, 1'b0, '0, '0);

    stall_mode = 1'b1;
    for (int n = 0; n < 24; n++) begin
      logic [31:0] v;
      v = 32'h9E37_79B9 * (n + 1);
      case (n % 4)
        0: send("R10 stalled write subword 0", A0, 1'b1, v, v ^ 32'h0F0F_F0F0);
        1: send("R10 stalled read subword 0", A0, 1'b0, '0, '0);
        2: send("R10 stalled write subword 1", A1, 1'b1, v, 32'hFF00_0000);
        default: send("R10 stalled read subword 1", A1, 1'b0, '0, '0);
      endcase
    end
    stall_mode = 1'b0;
    drain();
    check("R3 R4 ctrl_q after stalled traffic", ctrl_q, {m_f3, 32'h0, m_f1, m_f0});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule